// File: doc/BRIEF.md
# Exception-Return and Interrupt-Mode Control Slice

This block is the part of a coprocessor-0 unit that holds the processor's mode word, the revision/configuration word, the shadow-set control word, the debug control word, the interrupt cause word, the interrupt-line control word and three return addresses (normal, error and debug). It runs four single-cycle operations issued by the decode stage: interrupt disable, interrupt enable, exception return and debug return. It also applies the side effects of a coprocessor move to the timer compare register and filters reads of the page-mask register.

Operations arrive as a one-cycle strobe with a 3-bit opcode. Results are registered. The old mode word for the destination GPR, the reserved-instruction fault, the fetch redirect (target and following fetch address) and the clear of the load-linked flag all appear for exactly one cycle after the edge that accepts the operation. Software reaches the held words through an 8-bit `{register[4:0], select[2:0]}` write port and a combinational read port. Register numbers the block does not hold are passed through from `rd_ext_data`.

Top module: `cp0s_ctrl`

## Requirements
- R1: After reset the mode word reads 0x0040_0004 (bit 2 error level = 1, bit 22 boot vectors = 1, bit 0 interrupt enable = 0, all else 0). The configuration word reads RESET_REV in bits 12:10. No redirect, fault, GPR write or link clear is asserted.
- R2: When the configuration revision field (bits 12:10) is nonzero, opcode 1 (disable) and opcode 2 (enable) return the old mode word on `rt_data` with `rt_we` high in the next cycle. They clear or set mode bit 0 respectively.
- R3: When the revision field is zero, opcodes 1 and 2 raise `ri_fault` for one cycle, keep `rt_we` low and leave the mode word unchanged.
- R4: Opcode 3 (exception return) with mode bit 2 set clears bit 2, leaves bit 1 alone, and redirects to the error return address. The following fetch address is that target plus INST_BYTES.
- R5: Opcode 3 with mode bit 2 clear clears mode bit 1 and redirects to the normal return address. The following fetch address is that target plus INST_BYTES.
- R6: In the R5 path, shadow-control bits 3:0 take bits 9:6 only when all three conditions hold: the revision field is nonzero, bits 29:26 are nonzero, and mode bit 22 is 0. Otherwise the shadow-control word is unchanged.
- R7: Every exception return pulses `ll_clear` for one cycle. A debug return never does.
- R8: Opcode 4 (debug return) with debug bit 30 set keeps bit 30, clears debug bit 20, and redirects to the debug return address. With bit 30 clear it redirects nothing and changes nothing.
- R9: A write to address 0x58 (compare) while cause bit 30 is set clears cause bit 30 and cause bit 8+L, where L is interrupt-control bits 31:29. With cause bit 30 clear the cause word is unchanged.
- R10: A read of address 0x28 (page mask) returns `rd_ext_data` with bits 12:11 cleared unless both `small_page_cap` and `small_page_en` are 1. Other unheld addresses return `rd_ext_data` unmodified.
- R11: Writes to the held addresses update them: mode 0x60, interrupt control 0x61, shadow control 0x62, cause 0x68, normal return 0x70, configuration 0x80, debug 0xB8, debug return 0xC0, error return 0xF0. In the configuration word only bits 12:10 are writable.
- R12: `redirect_valid` is a one-cycle pulse per accepted return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Operation strobe |
| op_code | input | 3 | 1 disable, 2 enable, 3 exception return, 4 debug return |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Write address {register, select} |
| wr_data | input | XLEN | Write data |
| rd_addr | input | 8 | Read address {register, select} |
| rd_ext_data | input | XLEN | Value of unheld registers from elsewhere |
| small_page_cap | input | 1 | Small-page capability flag |
| small_page_en | input | 1 | Small-page enable flag |
| rd_data | output | XLEN | Read result |
| rt_data | output | XLEN | Old mode word for the destination GPR |
| rt_we | output | 1 | GPR write strobe |
| ri_fault | output | 1 | Reserved-instruction fault pulse |
| redirect_valid | output | 1 | Fetch redirect pulse |
| redirect_pc | output | XLEN | Redirect target |
| redirect_next_pc | output | XLEN | Fetch address after the target |
| ll_clear | output | 1 | Load-linked flag clear pulse |

## Verification
Every operation result and every register update lands on the first rising edge after the strobe. The bench raises a strobe at a falling edge, lowers it at the next falling edge and compares the pulsed outputs there, half a cycle after they change. One further cycle confirms that redirect has dropped. The read port and the page-mask filter are combinational, so they are compared 1 ns after `rd_addr` changes. Updates from writes and compare side effects are read back on the falling edge after the write edge.

// File: rtl/cp0s_pkg.sv
package cp0s_pkg;
   typedef enum logic [2:0] {
      OP_NONE    = 3'd0,
      OP_INT_OFF = 3'd1,
      OP_INT_ON  = 3'd2,
      OP_EXC_RET = 3'd3,
      OP_DBG_RET = 3'd4
   } cp0s_op_e;

   localparam int unsigned ADDR_W = 8;

   // {register number, select}
   localparam logic [7:0] A_PAGEMASK = {5'd5,  3'd0};
   localparam logic [7:0] A_COMPARE  = {5'd11, 3'd0};
   localparam logic [7:0] A_MODE     = {5'd12, 3'd0};
   localparam logic [7:0] A_INTCTL   = {5'd12, 3'd1};
   localparam logic [7:0] A_SHADOW   = {5'd12, 3'd2};
   localparam logic [7:0] A_CAUSE    = {5'd13, 3'd0};
   localparam logic [7:0] A_EPC      = {5'd14, 3'd0};
   localparam logic [7:0] A_CONFIG   = {5'd16, 3'd0};
   localparam logic [7:0] A_DEBUG    = {5'd23, 3'd0};
   localparam logic [7:0] A_DEPC     = {5'd24, 3'd0};
   localparam logic [7:0] A_ERRPC    = {5'd30, 3'd0};

   localparam int unsigned MODE_IE     = 0;
   localparam int unsigned MODE_EXL    = 1;
   localparam int unsigned MODE_ERL    = 2;
   localparam int unsigned MODE_BOOT   = 22;
   localparam int unsigned CFG_REV_LO  = 10;
   localparam int unsigned REV_W       = 3;
   localparam int unsigned SH_CUR_LO   = 0;
   localparam int unsigned SH_PREV_LO  = 6;
   localparam int unsigned SH_HIGH_LO  = 26;
   localparam int unsigned SH_W        = 4;
   localparam int unsigned CAUSE_TMR   = 30;
   localparam int unsigned CAUSE_PEND  = 8;
   localparam int unsigned ICTL_LINE   = 29;
   localparam int unsigned LINE_W      = 3;
   localparam int unsigned DBG_MODE    = 30;
   localparam int unsigned DBG_EXCINH  = 20;
   localparam int unsigned PM_GRAIN_LO = 11;
   localparam int unsigned MIN_XLEN    = 32;
endpackage

// File: rtl/cp0s_mode_regs.sv
module cp0s_mode_regs
   import cp0s_pkg::*;
#(
   parameter int unsigned XLEN      = 32,
   parameter int unsigned RESET_REV = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_valid,
   input  logic [2:0]        op_code,
   input  logic              wr_en,
   input  logic [7:0]        wr_addr,
   input  logic [XLEN-1:0]   wr_data,
   output logic [XLEN-1:0]   mode_q,
   output logic [XLEN-1:0]   cfg_q,
   output logic [XLEN-1:0]   rt_data,
   output logic              rt_we,
   output logic              ri_fault
);
   localparam logic [XLEN-1:0] MODE_RST =
      (XLEN'(1) << MODE_ERL) | (XLEN'(1) << MODE_BOOT);
   localparam logic [XLEN-1:0] CFG_RST = XLEN'(RESET_REV) << CFG_REV_LO;

   cp0s_op_e        op;
   logic            ie_op, legal;
   logic [XLEN-1:0] mode_d, cfg_d;

   assign op    = cp0s_op_e'(op_code);
   assign ie_op = op_valid && (op == OP_INT_OFF || op == OP_INT_ON);
   assign legal = (cfg_q[CFG_REV_LO +: REV_W] != '0);

   always_comb begin
      mode_d = mode_q;
      cfg_d  = cfg_q;
      if (wr_en && wr_addr == A_MODE)   mode_d = wr_data;
      if (wr_en && wr_addr == A_CONFIG)
         cfg_d[CFG_REV_LO +: REV_W] = wr_data[CFG_REV_LO +: REV_W];
      if (ie_op && legal) mode_d[MODE_IE] = (op == OP_INT_ON);
      if (op_valid && op == OP_EXC_RET) begin
         if (mode_q[MODE_ERL]) mode_d[MODE_ERL] = 1'b0;
         else                  mode_d[MODE_EXL] = 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q   <= MODE_RST;
         cfg_q    <= CFG_RST;
         rt_data  <= '0;
         rt_we    <= 1'b0;
         ri_fault <= 1'b0;
      end else begin
         mode_q   <= mode_d;
         cfg_q    <= cfg_d;
         rt_data  <= (ie_op && legal) ? mode_q : '0;
         rt_we    <= ie_op && legal;
         ri_fault <= ie_op && !legal;
      end
   end

   // R2
   int_off_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid && op == OP_INT_OFF && legal |=> !mode_q[MODE_IE]);
   // R3
   illegal_keeps_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ie_op && !legal && !wr_en |=> $stable(mode_q) && ri_fault && !rt_we);
   // R4
   err_level_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid && op == OP_EXC_RET && mode_q[MODE_ERL] |=> !mode_q[MODE_ERL]);
endmodule

// File: rtl/cp0s_cause_regs.sv
module cp0s_cause_regs
   import cp0s_pkg::*;
#(
   parameter int unsigned XLEN = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [7:0]        wr_addr,
   input  logic [XLEN-1:0]   wr_data,
   output logic [XLEN-1:0]   cause_q,
   output logic [XLEN-1:0]   ictl_q
);
   logic [XLEN-1:0] cause_d, ictl_d;
   logic            cmp_wr;
   logic [LINE_W-1:0] line;

   assign cmp_wr = wr_en && wr_addr == A_COMPARE;
   assign line   = ictl_q[ICTL_LINE +: LINE_W];

   always_comb begin
      cause_d = cause_q;
      ictl_d  = ictl_q;
      if (wr_en && wr_addr == A_CAUSE)  cause_d = wr_data;
      if (wr_en && wr_addr == A_INTCTL) ictl_d  = wr_data;
      if (cmp_wr && cause_q[CAUSE_TMR]) begin
         cause_d[CAUSE_TMR] = 1'b0;
         cause_d[CAUSE_PEND + 32'(line)] = 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cause_q <= '0;
         ictl_q  <= '0;
      end else begin
         cause_q <= cause_d;
         ictl_q  <= ictl_d;
      end
   end

   // R9
   timer_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_wr && cause_q[CAUSE_TMR] |=> !cause_q[CAUSE_TMR]);
   // R9
   no_ack_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_wr && !cause_q[CAUSE_TMR] |=> $stable(cause_q));
endmodule

// File: rtl/cp0s_return_path.sv
module cp0s_return_path
   import cp0s_pkg::*;
#(
   parameter int unsigned XLEN       = 32,
   parameter int unsigned INST_BYTES = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_valid,
   input  logic [2:0]        op_code,
   input  logic              wr_en,
   input  logic [7:0]        wr_addr,
   input  logic [XLEN-1:0]   wr_data,
   input  logic [XLEN-1:0]   mode_q,
   input  logic [REV_W-1:0]  rev,
   output logic [XLEN-1:0]   epc_q,
   output logic [XLEN-1:0]   errpc_q,
   output logic [XLEN-1:0]   depc_q,
   output logic [XLEN-1:0]   dbg_q,
   output logic [XLEN-1:0]   shadow_q,
   output logic              redirect_valid,
   output logic [XLEN-1:0]   redirect_pc,
   output logic [XLEN-1:0]   redirect_next_pc,
   output logic              ll_clear
);
   localparam int unsigned NUM_PC = 3;

   cp0s_op_e        op;
   logic            exc, dret, swap;
   logic [XLEN-1:0] dbg_d, shadow_d, target;
   logic [NUM_PC-1:0][XLEN-1:0] pc_w;

   assign op   = cp0s_op_e'(op_code);
   assign exc  = op_valid && op == OP_EXC_RET;
   assign dret = op_valid && op == OP_DBG_RET && dbg_q[DBG_MODE];
   assign swap = exc && !mode_q[MODE_ERL] && rev != '0 &&
                 shadow_q[SH_HIGH_LO +: SH_W] != '0 && !mode_q[MODE_BOOT];

   for (genvar g = 0; g < NUM_PC; g++) begin : g_pc
      localparam logic [7:0] MY_ADDR = (g == 0) ? A_EPC : (g == 1) ? A_ERRPC : A_DEPC;
      logic [XLEN-1:0] val;
      always_ff @(posedge clk) begin
         if (!rst_n)                          val <= '0;
         else if (wr_en && wr_addr == MY_ADDR) val <= wr_data;
      end
      assign pc_w[g] = val;
   end
   assign epc_q   = pc_w[0];
   assign errpc_q = pc_w[1];
   assign depc_q  = pc_w[2];

   always_comb begin
      dbg_d    = dbg_q;
      shadow_d = shadow_q;
      if (wr_en && wr_addr == A_DEBUG)  dbg_d    = wr_data;
      if (wr_en && wr_addr == A_SHADOW) shadow_d = wr_data;
      if (dret) begin
         dbg_d[DBG_MODE]   = 1'b1;
         dbg_d[DBG_EXCINH] = 1'b0;
      end
      if (swap) shadow_d[SH_CUR_LO +: SH_W] = shadow_q[SH_PREV_LO +: SH_W];
      if (exc) target = mode_q[MODE_ERL] ? errpc_q : epc_q;
      else     target = depc_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dbg_q            <= '0;
         shadow_q         <= '0;
         redirect_valid   <= 1'b0;
         redirect_pc      <= '0;
         redirect_next_pc <= '0;
         ll_clear         <= 1'b0;
      end else begin
         dbg_q            <= dbg_d;
         shadow_q         <= shadow_d;
         redirect_valid   <= exc || dret;
         redirect_pc      <= target;
         redirect_next_pc <= target + XLEN'(INST_BYTES);
         ll_clear         <= exc;
      end
   end

   // R7
   link_clear_on_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ll_clear |-> redirect_valid);
   // R8
   debug_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid && op == OP_DBG_RET && dbg_q[DBG_MODE]
      |=> dbg_q[DBG_MODE] && !dbg_q[DBG_EXCINH] && redirect_valid);
   // R8
   debug_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid && op == OP_DBG_RET && !dbg_q[DBG_MODE] && !wr_en |=> !redirect_valid && $stable(dbg_q));
endmodule

// File: rtl/cp0s_ctrl.sv
module cp0s_ctrl
   import cp0s_pkg::*;
#(
   parameter int unsigned XLEN        = 32,
   parameter int unsigned INST_BYTES  = 4,
   parameter int unsigned RESET_REV   = 1,
   parameter bit          SMALL_PAGES = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            op_valid,
   input  logic [2:0]      op_code,
   input  logic            wr_en,
   input  logic [7:0]      wr_addr,
   input  logic [XLEN-1:0] wr_data,
   input  logic [7:0]      rd_addr,
   input  logic [XLEN-1:0] rd_ext_data,
   input  logic            small_page_cap,
   input  logic            small_page_en,
   output logic [XLEN-1:0] rd_data,
   output logic [XLEN-1:0] rt_data,
   output logic            rt_we,
   output logic            ri_fault,
   output logic            redirect_valid,
   output logic [XLEN-1:0] redirect_pc,
   output logic [XLEN-1:0] redirect_next_pc,
   output logic            ll_clear
);
   if (XLEN < MIN_XLEN) begin : g_bad_xlen
      $error("XLEN must be at least 32");
   end
   if (INST_BYTES == 0 || (INST_BYTES & (INST_BYTES - 1)) != 0) begin : g_bad_inst
      $error("INST_BYTES must be a power of two");
   end
   if (RESET_REV >= (1 << REV_W)) begin : g_bad_rev
      $error("RESET_REV does not fit the revision field");
   end

   logic [XLEN-1:0] mode_q, cfg_q, cause_q, ictl_q;
   logic [XLEN-1:0] epc_q, errpc_q, depc_q, dbg_q, shadow_q;
   logic [XLEN-1:0] pm_view;
   logic            keep_fine;

   cp0s_mode_regs #(.XLEN(XLEN), .RESET_REV(RESET_REV)) u_mode (
      .clk, .rst_n, .op_valid, .op_code, .wr_en, .wr_addr, .wr_data,
      .mode_q, .cfg_q, .rt_data, .rt_we, .ri_fault);

   cp0s_return_path #(.XLEN(XLEN), .INST_BYTES(INST_BYTES)) u_ret (
      .clk, .rst_n, .op_valid, .op_code, .wr_en, .wr_addr, .wr_data,
      .mode_q, .rev(cfg_q[CFG_REV_LO +: REV_W]),
      .epc_q, .errpc_q, .depc_q, .dbg_q, .shadow_q,
      .redirect_valid, .redirect_pc, .redirect_next_pc, .ll_clear);

   cp0s_cause_regs #(.XLEN(XLEN)) u_cause (
      .clk, .rst_n, .wr_en, .wr_addr, .wr_data, .cause_q, .ictl_q);

   if (SMALL_PAGES) begin : g_fine_pages
      assign keep_fine = small_page_cap && small_page_en;
   end else begin : g_coarse_pages
      assign keep_fine = 1'b0;
   end

   always_comb begin
      pm_view = rd_ext_data;
      if (!keep_fine) pm_view[PM_GRAIN_LO +: 2] = 2'b00;
      case (rd_addr)
         A_MODE:     rd_data = mode_q;
         A_CONFIG:   rd_data = cfg_q;
         A_INTCTL:   rd_data = ictl_q;
         A_SHADOW:   rd_data = shadow_q;
         A_CAUSE:    rd_data = cause_q;
         A_EPC:      rd_data = epc_q;
         A_ERRPC:    rd_data = errpc_q;
         A_DEPC:     rd_data = depc_q;
         A_DEBUG:    rd_data = dbg_q;
         A_PAGEMASK: rd_data = pm_view;
         default:    rd_data = rd_ext_data;
      endcase
   end

   // R12
   redirect_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
      redirect_valid |-> redirect_next_pc == redirect_pc + XLEN'(INST_BYTES));
   // R3
   fault_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(ri_fault && rt_we));
endmodule

// File: tb/tb_cp0s_ctrl.sv
`timescale 1ns/1ps
module tb_cp0s_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        op_valid = 1'b0;
   logic [2:0]  op_code = '0;
   logic        wr_en = 1'b0;
   logic [7:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic [7:0]  rd_addr = '0;
   logic [31:0] rd_ext_data = '0;
   logic        small_page_cap = 1'b0;
   logic        small_page_en = 1'b0;
   logic [31:0] rd_data, rt_data, redirect_pc, redirect_next_pc;
   logic        rt_we, ri_fault, redirect_valid, ll_clear;

   int n_chk = 0;
   int n_bad = 0;

   cp0s_ctrl dut (.*);

   always #2.5 clk = ~clk;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input string req, input logic [7:0] a, input logic [31:0] exp);
      rd_addr = a;
      #1;
      chk(req, rd_data, exp);
   endtask

   task automatic op(input logic [2:0] c);
      @(negedge clk);
      op_valid = 1'b1; op_code = c;
      @(negedge clk);
      op_valid = 1'b0; op_code = '0;
   endtask

   task automatic t_reset;
      rd("R1 mode", 8'h60, 32'h0040_0004);
      rd("R1 config", 8'h80, 32'h0000_0400);
      chk("R1 redirect", {31'b0, redirect_valid}, 0);
      chk("R1 fault", {31'b0, ri_fault}, 0);
      chk("R1 llclear", {31'b0, ll_clear}, 0);
      chk("R1 rtwe", {31'b0, rt_we}, 0);
   endtask

   task automatic t_int_ops;
      op(3'd1);
      chk("R2 off rtwe", {31'b0, rt_we}, 1);
      chk("R2 off rt", rt_data, 32'h0040_0004);
      rd("R2 off mode", 8'h60, 32'h0040_0004);
      op(3'd2);
      chk("R2 on rt", rt_data, 32'h0040_0004);
      rd("R2 on mode", 8'h60, 32'h0040_0005);
      op(3'd1);
      chk("R2 off2 rt", rt_data, 32'h0040_0005);
      rd("R2 off2 mode", 8'h60, 32'h0040_0004);
   endtask

   task automatic t_rev_zero;
      wr(8'h80, 32'h0);
      rd("R11 config zero", 8'h80, 32'h0);
      op(3'd2);
      chk("R3 fault", {31'b0, ri_fault}, 1);
      chk("R3 rtwe", {31'b0, rt_we}, 0);
      rd("R3 mode kept", 8'h60, 32'h0040_0004);
      op(3'd1);
      chk("R3 fault off", {31'b0, ri_fault}, 1);
      wr(8'h80, 32'hFFFF_FFFF);
      rd("R11 config mask", 8'h80, 32'h0000_1C00);
      wr(8'h80, 32'h0000_0400);
   endtask

   task automatic t_exc_err;
      wr(8'h70, 32'h0000_1000);
      wr(8'hF0, 32'h0000_2000);
      rd("R11 epc", 8'h70, 32'h0000_1000);
      wr(8'h60, 32'h0040_0006);
      op(3'd3);
      chk("R4 valid", {31'b0, redirect_valid}, 1);
      chk("R4 pc", redirect_pc, 32'h0000_2000);
      chk("R4 next", redirect_next_pc, 32'h0000_2004);
      chk("R7 llclear", {31'b0, ll_clear}, 1);
      rd("R4 mode", 8'h60, 32'h0040_0002);
      @(negedge clk);
      chk("R12 drop", {31'b0, redirect_valid}, 0);
      chk("R7 drop", {31'b0, ll_clear}, 0);
   endtask

   task automatic t_exc_norm;
      wr(8'h62, 32'h0400_0142);
      op(3'd3);
      chk("R5 pc", redirect_pc, 32'h0000_1000);
      chk("R5 next", redirect_next_pc, 32'h0000_1004);
      chk("R7 llclear2", {31'b0, ll_clear}, 1);
      rd("R5 mode", 8'h60, 32'h0040_0000);
      rd("R6 boot blocks", 8'h62, 32'h0400_0142);
      wr(8'h60, 32'h0000_0002);
      op(3'd3);
      rd("R5 mode2", 8'h60, 32'h0000_0000);
      rd("R6 swap", 8'h62, 32'h0400_0145);
      wr(8'h62, 32'h0000_0142);
      op(3'd3);
      rd("R6 high zero", 8'h62, 32'h0000_0142);
   endtask

   task automatic t_dbg;
      wr(8'hB8, 32'h0010_0000);
      wr(8'hC0, 32'h0000_3000);
      op(3'd4);
      chk("R8 idle valid", {31'b0, redirect_valid}, 0);
      rd("R8 idle debug", 8'hB8, 32'h0010_0000);
      wr(8'hB8, 32'h4010_0000);
      op(3'd4);
      chk("R8 valid", {31'b0, redirect_valid}, 1);
      chk("R8 pc", redirect_pc, 32'h0000_3000);
      chk("R8 next", redirect_next_pc, 32'h0000_3004);
      chk("R7 no llclear", {31'b0, ll_clear}, 0);
      rd("R8 debug", 8'hB8, 32'h4000_0000);
   endtask

   task automatic t_compare;
      wr(8'h61, 32'hA000_0000);
      wr(8'h68, 32'h4000_FF00);
      wr(8'h58, 32'h1234_5678);
      rd("R9 line5", 8'h68, 32'h0000_DF00);
      wr(8'h58, 32'h0);
      rd("R9 no tmr", 8'h68, 32'h0000_DF00);
      wr(8'h61, 32'h4000_0000);
      wr(8'h68, 32'h4000_FF00);
      wr(8'h58, 32'h0);
      rd("R9 line2", 8'h68, 32'h0000_FB00);
   endtask

   task automatic t_pagemask;
      rd_ext_data = 32'hFFFF_FFFF;
      small_page_cap = 1'b1; small_page_en = 1'b1;
      rd("R10 both", 8'h28, 32'hFFFF_FFFF);
      small_page_en = 1'b0;
      rd("R10 en off", 8'h28, 32'hFFFF_E7FF);
      small_page_cap = 1'b0; small_page_en = 1'b1;
      rd("R10 cap off", 8'h28, 32'hFFFF_E7FF);
      rd("R10 passthru", 8'h30, 32'hFFFF_FFFF);
   endtask

   initial begin
      #(200000 * 5);
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_int_ops();
      t_rev_zero();
      t_exc_err();
      t_exc_norm();
      t_dbg();
      t_compare();
      t_pagemask();
      @(negedge clk);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule